// File: doc/BRIEF.md
# Debug Address Match Unit

This block watches a bus for accesses that fall on addresses a debugger has armed. It has four address slots. Each slot has an enable pair and a 4-bit code in a shared 32-bit control word. The code sets which access kind the slot reacts to and how large an aligned region it covers. Every access offered on the observation port is compared against all enabled slots in the same cycle. A match sets that slot's bit in a sticky status register, and a single trap output stays high while any status bit is set.

Software reaches the four slot addresses, the status register and the control word through a simple indexed register port. Writes take effect at the clock edge and reads are combinational. Software clears status by writing zeros to it. A slot is free whenever both of its enable bits are zero.

Top module: `dbg_match_unit`

## Requirements
- R1: After reset all slot addresses, the control word and the status register read zero, and trap is low.
- R2: A control write stores bits 0 to 9 and 16 to 31 as written, and bits 10 to 15 always read back as zero.
- R3: Slot i is enabled when control bit 2i or control bit 2i+1 is set, and either bit alone is enough. A slot with both bits clear never sets its status bit.
- R4: Slot i takes its field from control bits 16+4i to 19+4i. The low pair is the access code and the high pair is the length code. Access code 00 matches only a fetch (acc_kind 00) whose address equals the slot address exactly, whatever the length code and fetch size are.
- R5: Access code 01 matches data writes (acc_kind 10) and ignores data reads.
- R6: Access code 11 matches data reads (acc_kind 01) and data writes. It matches neither fetches nor I/O.
- R7: Access code 10 matches I/O accesses (acc_kind 11) only.
- R8: Length codes are 00 for 1 byte, 01 for 2, 11 for 4 and 10 for 8. The region starts at the slot address with its low bits cleared to that size. A data or I/O slot matches when any byte of the access lies inside the region. acc_size codes 00, 01, 10 and 11 mean 1, 2, 4 and 8 bytes.
- R9: When the wide-mode parameter is 0, a slot with length code 10 never matches.
- R10: Control bits 8 and 9 are stored and read back, and they do not change matching.
- R11: Status bit i is set in the cycle after a matching access on slot i. It stays set until software writes 0 to it. A status write loads bits 3:0, and a match in the same cycle still sets its bit.
- R12: trap is high exactly when any status bit is set. It rises with the status update that follows a matching access.
- R13: The register indices are 0 to 3 for the slot addresses, 4 for status (bits 3:0) and 5 for control. Indices 6 and 7 read zero and ignore writes. Several slots can match one access, and each sets its own bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index for read and write |
| reg_wdata | input | ADDR_W | Write data |
| reg_rdata | output | ADDR_W | Read data for reg_idx, combinational |
| acc_valid | input | 1 | An access is present this cycle |
| acc_addr | input | ADDR_W | Access start address |
| acc_size | input | 2 | Access size code |
| acc_kind | input | 2 | Access kind: fetch, read, write, I/O |
| trap | output | 1 | High while any status bit is set |

## Verification
A wrong decode of an enable pair or a field slice shows up at the ports one cycle after the access that exposes it. That error either sets a status bit and raises trap where nothing should match, or leaves trap low where a hit was due. The region arithmetic is stressed at both ends of each aligned window and with accesses that straddle a window edge from below. A fault in the sticky logic or the reserved mask stays hidden until the next status or control read, so the bench reads back after every access and every write.

// File: rtl/dbgm_pkg.sv
package dbgm_pkg;
    localparam int SLOTS      = 4;
    localparam int CTRL_W     = 32;
    localparam int FIELD_BASE = 16;
    localparam int FIELD_W    = 4;
    localparam int IDX_W      = 3;
    localparam int MASK_W     = 3;

    localparam logic [IDX_W-1:0]  IDX_STATUS = 3'd4;
    localparam logic [IDX_W-1:0]  IDX_CTRL   = 3'd5;
    localparam logic [CTRL_W-1:0] CTRL_RSVD  = 32'h0000_FC00;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'b00,
        ACC_READ  = 2'b01,
        ACC_WRITE = 2'b10,
        ACC_IO    = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        RW_EXEC  = 2'b00,
        RW_WRITE = 2'b01,
        RW_IO    = 2'b10,
        RW_DATA  = 2'b11
    } rw_code_e;

    typedef enum logic [1:0] {
        LEN_1 = 2'b00,
        LEN_2 = 2'b01,
        LEN_8 = 2'b10,
        LEN_4 = 2'b11
    } len_code_e;

    typedef struct packed {
        logic              en;
        rw_code_e          rw;
        logic              len_ok;
        logic [MASK_W-1:0] len_mask;
    } slot_cfg_t;
endpackage

// File: rtl/dbgm_field_dec.sv
module dbgm_field_dec
    import dbgm_pkg::*;
#(
    parameter bit WIDE_EN = 1'b1
) (
    input  logic [1:0]         en_bits,
    input  logic [FIELD_W-1:0] field,
    output slot_cfg_t          cfg
);
    always_comb begin
        cfg.en       = |en_bits;
        cfg.rw       = rw_code_e'(field[1:0]);
        cfg.len_ok   = 1'b1;
        cfg.len_mask = '0;
        case (len_code_e'(field[3:2]))
            LEN_1: cfg.len_mask = 3'd0;
            LEN_2: cfg.len_mask = 3'd1;
            LEN_4: cfg.len_mask = 3'd3;
            LEN_8: begin
                cfg.len_mask = 3'd7;
                cfg.len_ok   = WIDE_EN;
            end
            default: cfg.len_mask = 3'd0;
        endcase
    end
endmodule

// File: rtl/dbgm_slot_cmp.sv
module dbgm_slot_cmp
    import dbgm_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  slot_cfg_t         cfg,
    input  logic [ADDR_W-1:0] slot_addr,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    input  logic [1:0]        acc_kind,
    output logic              hit
);
    localparam int EW = ADDR_W + 1;

    logic              kind_ok;
    logic [MASK_W-1:0] size_mask;
    logic [EW-1:0]     reg_lo, reg_hi, acc_lo, acc_hi;
    logic              overlap;

    always_comb begin
        case (acc_size)
            2'b00:   size_mask = 3'd0;
            2'b01:   size_mask = 3'd1;
            2'b10:   size_mask = 3'd3;
            default: size_mask = 3'd7;
        endcase

        case (cfg.rw)
            RW_EXEC:  kind_ok = (acc_kind == ACC_FETCH);
            RW_WRITE: kind_ok = (acc_kind == ACC_WRITE);
            RW_DATA:  kind_ok = (acc_kind == ACC_READ) || (acc_kind == ACC_WRITE);
            default:  kind_ok = (acc_kind == ACC_IO);
        endcase

        reg_lo  = {1'b0, slot_addr & ~ADDR_W'(cfg.len_mask)};
        reg_hi  = reg_lo + EW'(cfg.len_mask);
        acc_lo  = {1'b0, acc_addr};
        acc_hi  = acc_lo + EW'(size_mask);
        overlap = (acc_lo <= reg_hi) && (acc_hi >= reg_lo);

        if (cfg.rw == RW_EXEC)
            hit = cfg.en && acc_valid && kind_ok && (acc_addr == slot_addr);
        else
            hit = cfg.en && acc_valid && kind_ok && cfg.len_ok && overlap;
    end
endmodule

// File: rtl/dbgm_regs.sv
module dbgm_regs
    import dbgm_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [ADDR_W-1:0]           wdata,
    input  logic [SLOTS-1:0]            hits,
    output logic [SLOTS-1:0][ADDR_W-1:0] addr_o,
    output logic [CTRL_W-1:0]           ctrl_o,
    output logic [SLOTS-1:0]            status_o
);
    typedef struct packed {
        logic [SLOTS-1:0][ADDR_W-1:0] addr;
        logic [CTRL_W-1:0]            ctrl;
        logic [SLOTS-1:0]             status;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (wr_idx < IDX_W'(SLOTS))
                st_d.addr[wr_idx[1:0]] = wdata;
            else if (wr_idx == IDX_STATUS)
                st_d.status = wdata[SLOTS-1:0];
            else if (wr_idx == IDX_CTRL)
                st_d.ctrl = wdata[CTRL_W-1:0] & ~CTRL_RSVD;
        end
        st_d.status = st_d.status | hits;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign addr_o   = st_q.addr;
    assign ctrl_o   = st_q.ctrl;
    assign status_o = st_q.status;
endmodule

// File: rtl/dbg_match_unit.sv
module dbg_match_unit
    import dbgm_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter bit WIDE_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [2:0]        reg_idx,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    input  logic [1:0]        acc_kind,
    output logic              trap
);
    logic [SLOTS-1:0][ADDR_W-1:0] slot_addr;
    logic [CTRL_W-1:0]            ctrl_q;
    logic [SLOTS-1:0]             status_q;
    logic [SLOTS-1:0]             slot_hit;
    logic [SLOTS-1:0]             slot_en;

    dbgm_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .wr_idx   (reg_idx),
        .wdata    (reg_wdata),
        .hits     (slot_hit),
        .addr_o   (slot_addr),
        .ctrl_o   (ctrl_q),
        .status_o (status_q)
    );

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        slot_cfg_t cfg;

        dbgm_field_dec #(.WIDE_EN(WIDE_EN)) u_dec (
            .en_bits (ctrl_q[2*s+1 : 2*s]),
            .field   (ctrl_q[FIELD_BASE+FIELD_W*s +: FIELD_W]),
            .cfg     (cfg)
        );

        dbgm_slot_cmp #(.ADDR_W(ADDR_W)) u_cmp (
            .cfg       (cfg),
            .slot_addr (slot_addr[s]),
            .acc_valid (acc_valid),
            .acc_addr  (acc_addr),
            .acc_size  (acc_size),
            .acc_kind  (acc_kind),
            .hit       (slot_hit[s])
        );

        assign slot_en[s] = cfg.en;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_idx < 3'(SLOTS))
            reg_rdata = slot_addr[reg_idx[1:0]];
        else if (reg_idx == IDX_STATUS)
            reg_rdata = ADDR_W'(status_q);
        else if (reg_idx == IDX_CTRL)
            reg_rdata = ADDR_W'(ctrl_q);
    end

    assign trap = |status_q;
endmodule

// File: rtl/dbgm_chk.sv
module dbgm_chk
    import dbgm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic [2:0]        reg_idx,
    input logic [CTRL_W-1:0] ctrl,
    input logic [SLOTS-1:0]  status,
    input logic [SLOTS-1:0]  hits,
    input logic [SLOTS-1:0]  slot_en,
    input logic              trap
);
    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl[15:10] == 6'b0);

    // R3
    vacant_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hits & ~slot_en) == '0);

    // R11
    hit_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hits != '0) |=> ((status & $past(hits)) == $past(hits)));

    // R11
    sticky_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_en && reg_idx == IDX_STATUS) |=> ((status & $past(status)) == $past(status)));

    // R12
    trap_after_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hits != '0) |=> trap);
endmodule

bind dbg_match_unit dbgm_chk u_dbgm_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr_en (reg_wr_en),
    .reg_idx   (reg_idx),
    .ctrl      (ctrl_q),
    .status    (status_q),
    .hits      (slot_hit),
    .slot_en   (slot_en),
    .trap      (trap)
);

// File: tb/test_dbg_match_unit.sv
module test_dbg_match_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] rdata_w, rdata_n;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_size = '0;
    logic [1:0]  acc_kind = '0;
    logic        trap_w, trap_n;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dbg_match_unit #(.ADDR_W(32), .WIDE_EN(1'b1)) i_dbg_match_unit (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(rdata_w), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .acc_size(acc_size), .acc_kind(acc_kind), .trap(trap_w));

    dbg_match_unit #(.ADDR_W(32), .WIDE_EN(1'b0)) i_dbg_match_unit_nar (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(rdata_n), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .acc_size(acc_size), .acc_kind(acc_kind), .trap(trap_n));

    typedef struct packed {
        logic [3:0]  fld;
        logic [31:0] sa;
        logic [31:0] aa;
        logic [1:0]  sz;
        logic [1:0]  kd;
        logic        hit;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{4'b0000, 32'h1000, 32'h1000, 2'd0, 2'd0, 1'b1},
        '{4'b0000, 32'h1000, 32'h1001, 2'd0, 2'd0, 1'b0},
        '{4'b0000, 32'h1000, 32'h1000, 2'd0, 2'd1, 1'b0},
        '{4'b1101, 32'h2002, 32'h2003, 2'd0, 2'd2, 1'b1},
        '{4'b1101, 32'h2002, 32'h2004, 2'd0, 2'd2, 1'b0},
        '{4'b1101, 32'h2002, 32'h1FFF, 2'd1, 2'd2, 1'b1},
        '{4'b1101, 32'h2002, 32'h2000, 2'd0, 2'd1, 1'b0},
        '{4'b0111, 32'h3001, 32'h3001, 2'd0, 2'd1, 1'b1},
        '{4'b0111, 32'h3001, 32'h3002, 2'd0, 2'd2, 1'b0},
        '{4'b0111, 32'h3001, 32'h3000, 2'd0, 2'd0, 1'b0},
        '{4'b0010, 32'h0060, 32'h0060, 2'd0, 2'd3, 1'b1},
        '{4'b0010, 32'h0060, 32'h0060, 2'd0, 2'd2, 1'b0},
        '{4'b1011, 32'h4005, 32'h4007, 2'd0, 2'd1, 1'b1},
        '{4'b1011, 32'h4005, 32'h4008, 2'd0, 2'd1, 1'b0},
        '{4'b1011, 32'h4005, 32'h3FFC, 2'd2, 2'd2, 1'b0},
        '{4'b1011, 32'h4005, 32'h3FFC, 2'd3, 2'd2, 1'b1},
        '{4'b0001, 32'h5003, 32'h5000, 2'd2, 2'd2, 1'b1},
        '{4'b1100, 32'h7000, 32'h7000, 2'd3, 2'd0, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_idx = idx; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic acc(input logic [31:0] a, input logic [1:0] sz, input logic [1:0] kd);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_size = sz; acc_kind = kd;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic rd(input logic [2:0] idx, output logic [31:0] d);
        reg_idx = idx;
        #1;
        d = rdata_w;
    endtask

    function automatic string rq(input int k);
        vec_t v;
        v = VECS[k];
        case (v.fld[1:0])
            2'b00:   return $sformatf("R4 vec%0d", k);
            2'b01:   return $sformatf("R5 R8 vec%0d", k);
            2'b11:   return $sformatf("R6 R8 vec%0d", k);
            default: return $sformatf("R7 vec%0d", k);
        endcase
    endfunction

    initial begin
        #800000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int i = 0; i < 6; i++) begin
            rd(3'(i), d);
            check($sformatf("R1 idx%0d", i), d, 32'h0);
        end
        check("R1 trap", {31'b0, trap_w}, 32'h0);

        // R2 R10 control readback
        wr(3'd5, 32'hFFFF_FFFF);
        rd(3'd5, d);
        check("R2 R10 ctrl mask", d, 32'hFFFF_03FF);
        wr(3'd5, 32'h0);

        // vector table, slot 0
        for (int k = 0; k < NV; k++) begin
            wr(3'd0, VECS[k].sa);
            wr(3'd5, 32'h1 | (32'(VECS[k].fld) << 16));
            wr(3'd4, 32'h0);
            acc(VECS[k].aa, VECS[k].sz, VECS[k].kd);
            rd(3'd4, d);
            check(rq(k), d, {31'b0, VECS[k].hit});
            check({"R12 ", rq(k)}, {31'b0, trap_w}, {31'b0, VECS[k].hit});
        end

        // R10 exact flags do not change matching
        wr(3'd0, 32'h1000);
        wr(3'd5, 32'h0000_0301);
        wr(3'd4, 32'h0);
        acc(32'h1000, 2'd0, 2'd0);
        rd(3'd4, d);
        check("R10 flags set hit", d, 32'h1);
        wr(3'd4, 32'h0);
        acc(32'h1001, 2'd0, 2'd0);
        rd(3'd4, d);
        check("R10 flags set miss", d, 32'h0);

        // R3 vacant slot 1, then global-only enable
        wr(3'd1, 32'h8000);
        wr(3'd5, 32'h0);
        wr(3'd4, 32'h0);
        acc(32'h8000, 2'd0, 2'd0);
        rd(3'd4, d);
        check("R3 vacant", d, 32'h0);
        check("R3 vacant trap", {31'b0, trap_w}, 32'h0);
        wr(3'd5, 32'h0000_0008);
        acc(32'h8000, 2'd0, 2'd0);
        rd(3'd4, d);
        check("R3 global enable", d, 32'h2);

        // R13 two slots hit one access; field position of slot 3
        wr(3'd3, 32'h8001);
        wr(3'd5, 32'h3000_0048 | 32'h0000_0000);
        wr(3'd4, 32'h0);
        acc(32'h8000, 2'd1, 2'd1);
        rd(3'd4, d);
        check("R13 R4 two slots, exec ignores read", d, 32'h8);
        wr(3'd5, 32'hD000_0048);
        wr(3'd4, 32'h0);
        acc(32'h8000, 2'd1, 2'd2);
        rd(3'd4, d);
        check("R13 R8 slot3 4B write", d, 32'h8);
        acc(32'h8000, 2'd0, 2'd0);
        rd(3'd4, d);
        check("R13 both bits", d, 32'hA);

        // R11 sticky, partial clear, clear racing a hit
        repeat (3) @(negedge clk);
        rd(3'd4, d);
        check("R11 sticky", d, 32'hA);
        wr(3'd4, 32'h8);
        rd(3'd4, d);
        check("R11 partial clear", d, 32'h8);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_idx = 3'd4; reg_wdata = 32'h0;
        acc_valid = 1'b1; acc_addr = 32'h8000; acc_size = 2'd0; acc_kind = 2'd0;
        @(negedge clk);
        reg_wr_en = 1'b0; acc_valid = 1'b0;
        rd(3'd4, d);
        check("R11 hit beats clear", d, 32'h2);
        wr(3'd4, 32'h0);
        rd(3'd4, d);
        check("R11 cleared", d, 32'h0);
        check("R12 trap low", {31'b0, trap_w}, 32'h0);

        // R9 narrow instance ignores 8-byte code
        wr(3'd0, 32'h4000);
        wr(3'd5, 32'h000B_0001);
        wr(3'd4, 32'h0);
        acc(32'h4004, 2'd0, 2'd1);
        #1;
        check("R9 wide hit", {31'b0, trap_w}, 32'h1);
        check("R9 narrow no hit", {31'b0, trap_n}, 32'h0);

        // R13 unused indices
        wr(3'd6, 32'hDEAD_BEEF);
        wr(3'd7, 32'hDEAD_BEEF);
        rd(3'd6, d);
        check("R13 idx6", d, 32'h0);
        rd(3'd7, d);
        check("R13 idx7", d, 32'h0);
        rd(3'd0, d);
        check("R13 addr0 intact", d, 32'h4000);
        rd(3'd5, d);
        check("R13 ctrl intact", d, 32'h000B_0001);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule